// File: doc/BRIEF.md
# Root Port Legacy Interrupt Status Aggregator

This block collects the interrupt-style events a PCIe root port sees and turns them into one level interrupt for the local processor. Four legacy interrupt wires (INTA to INTD, as signalled by the endpoint) and one event marking the return of a completion for an outstanding non-posted request on the direct TLP channel each set a sticky flag. Software reads the flags, acknowledges them by writing ones, and picks which flags may raise the interrupt through a separate mask register.

Message-signalled interrupts (MSI and MSI-X) are ordinary memory writes. The block only forwards a flag for them and never lets them influence the interrupt level. Register access goes through a 32-bit port. Writes complete in the cycle they are presented. Reads return data one cycle later, together with a valid strobe.

Each flag is a two-state machine. The states are FLAG_CLEAR and FLAG_PENDING. The transitions are: raise (FLAG_CLEAR to FLAG_PENDING on an event), acknowledge (FLAG_PENDING to FLAG_CLEAR on a write-one-clear with no event in that cycle) and hold (any other case). The read port is also a machine, with states RD_IDLE and RD_VALID. Its transitions are: issue (RD_IDLE to RD_VALID on a read), stream (RD_VALID to RD_VALID on a back-to-back read) and retire (RD_VALID to RD_IDLE when no read is presented).

Top module: `rp_irq_aggregator`

## Requirements
- R1: After reset, the flag register and the mask register read 0, irq_o is 0 and reg_rvalid is 0.
- R2: An event pulse sets its flag in the next cycle. intx_evt[0..3] set flag bits 0..3 (INTA..INTD) and cpl_evt sets flag bit 4. The flags are read at offset 0x3060.
- R3: A set flag stays set until software writes 1 to its bit at offset 0x3060. Writing 0 to a bit leaves that bit unchanged.
- R4: If an event and a write-one-clear reach the same flag in the same cycle, the flag stays set.
- R5: The mask register at offset 0x3070 holds bits [4:0] as plain read/write bits. Bit n of the mask enables flag bit n.
- R6: irq_o is a level signal. It equals the OR of (flags AND mask), registered, so it changes one cycle after the flags or the mask change.
- R7: Bits [31:5] of both registers always read 0. Writes to those bits are ignored.
- R8: A read of any offset other than 0x3060 or 0x3070 returns 0. A write to such an offset changes neither register.
- R9: Each read presented in cycle n gives reg_rvalid high with the data in cycle n+1. reg_rvalid is low in a cycle that follows a cycle with no read.
- R10: msi_fwd_o follows msi_fwd_i unchanged. A message-signalled interrupt never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 16 | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| intx_evt | input | 4 | Legacy interrupt receive pulses, bit 0 = INTA |
| cpl_evt | input | 1 | Completion-received pulse for the direct TLP channel |
| msi_fwd_i | input | 1 | Message-signalled interrupt write seen |
| msi_fwd_o | output | 1 | Forwarded message interrupt flag |
| irq_o | output | 1 | Level interrupt to the local processor |

## Verification
The assertions assume that event inputs and register strobes are stable across each clock edge and are already at zero while reset is asserted. They also assume that a read and a write to the same offset in one cycle returns the value from before the write. The stimulus meets these assumptions by driving every input on the falling edge, holding all inputs at zero during reset, and never overlapping a read with a write. The sweeps run through every event pattern against every mask pattern, and every pending pattern against every clear mask. This gives an exhaustive check of the level logic and of the acknowledge rule for five sources.

// File: rtl/rp_irq_pkg.sv
package rp_irq_pkg;

    localparam int INTX_LINES = 4;
    localparam int SRC_CNT    = INTX_LINES + 1;
    localparam int CPL_BIT    = INTX_LINES;

    typedef enum logic {
        FLAG_CLEAR   = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_t;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_VALID = 1'b1
    } rd_state_t;

endpackage

// File: rtl/rp_irq_flag_bank.sv
module rp_irq_flag_bank
    import rp_irq_pkg::*;
#(
    parameter int NSRC = SRC_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic            clr_stb_i,
    input  logic [NSRC-1:0] clr_mask_i,
    output logic [NSRC-1:0] flags_o
);

    for (genvar gi = 0; gi < NSRC; gi++) begin : g_flag
        flag_state_t state_q, state_d;
        logic        ack;

        assign ack = clr_stb_i && clr_mask_i[gi];

        always_ff @(posedge clk) begin
            if (!rst_n) state_q <= FLAG_CLEAR;
            else        state_q <= state_d;
        end

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                FLAG_CLEAR:   if (evt_i[gi])         state_d = FLAG_PENDING;
                FLAG_PENDING: if (ack && !evt_i[gi]) state_d = FLAG_CLEAR;
            endcase
        end

        assign flags_o[gi] = (state_q == FLAG_PENDING);

        assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[gi] |=> flags_o[gi]);
        assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flags_o[gi] && !ack) |=> flags_o[gi]);
        assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && !evt_i[gi]) |=> !flags_o[gi]);
        assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ack && evt_i[gi]) |=> flags_o[gi]);
    end

endmodule

// File: rtl/rp_irq_mask_reg.sv
module rp_irq_mask_reg
    import rp_irq_pkg::*;
#(
    parameter int NSRC = SRC_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_stb_i,
    input  logic [NSRC-1:0] wdata_i,
    output logic [NSRC-1:0] mask_o
);

    logic [NSRC-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        mask_q <= '0;
        else if (wr_stb_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_i |=> (mask_o == $past(wdata_i)));
    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb_i |=> $stable(mask_o));

endmodule

// File: rtl/rp_irq_rd_port.sv
module rp_irq_rd_port
    import rp_irq_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 16,
    parameter int                NSRC     = SRC_CNT,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 16'h3060,
    parameter logic [ADDR_W-1:0] MASK_OFS = 16'h3070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   flags_i,
    input  logic [NSRC-1:0]   mask_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);

    localparam int PAD_W = DATA_W - NSRC;

    rd_state_t         state_q, state_d;
    logic [DATA_W-1:0] rdata_q, sel_word;

    always_comb begin
        if (addr_i == FLAG_OFS)      sel_word = {{PAD_W{1'b0}}, flags_i};
        else if (addr_i == MASK_OFS) sel_word = {{PAD_W{1'b0}}, mask_i};
        else                         sel_word = '0;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE:  if (rd_i)  state_d = RD_VALID;
            RD_VALID: if (!rd_i) state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    rdata_q <= '0;
        else if (rd_i) rdata_q <= sel_word;
    end

    assign rvalid_o = (state_q == RD_VALID);
    assign rdata_o  = rdata_q;

    assert_rd_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> rvalid_o);
    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> !rvalid_o);
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid_o |-> (rdata_o[DATA_W-1:NSRC] == '0));
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i != FLAG_OFS && addr_i != MASK_OFS) |=> (rdata_o == '0));

endmodule

// File: rtl/rp_irq_level.sv
module rp_irq_level
    import rp_irq_pkg::*;
#(
    parameter int NSRC = SRC_CNT
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] flags_i,
    input  logic [NSRC-1:0] mask_i,
    output logic            irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_i & mask_i);
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/rp_irq_aggregator.sv
module rp_irq_aggregator
    import rp_irq_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 16,
    parameter int                NINTX    = INTX_LINES,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 16'h3060,
    parameter logic [ADDR_W-1:0] MASK_OFS = 16'h3070
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_rd,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    input  logic [NINTX-1:0]  intx_evt,
    input  logic              cpl_evt,
    input  logic              msi_fwd_i,
    output logic              msi_fwd_o,
    output logic              irq_o
);

    localparam int NSRC = NINTX + 1;

    logic [NSRC-1:0] events, flags, mask;
    logic            flag_wr, mask_wr;
    logic            unused_wdata_hi;

    assign events  = {cpl_evt, intx_evt};
    assign flag_wr = reg_wr && (reg_addr == FLAG_OFS);
    assign mask_wr = reg_wr && (reg_addr == MASK_OFS);
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NSRC];

    rp_irq_flag_bank #(.NSRC(NSRC)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (events),
        .clr_stb_i (flag_wr),
        .clr_mask_i(reg_wdata[NSRC-1:0]),
        .flags_o   (flags)
    );

    rp_irq_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb_i(mask_wr),
        .wdata_i (reg_wdata[NSRC-1:0]),
        .mask_o  (mask)
    );

    rp_irq_rd_port #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NSRC    (NSRC),
        .FLAG_OFS(FLAG_OFS),
        .MASK_OFS(MASK_OFS)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_i    (reg_rd),
        .addr_i  (reg_addr),
        .flags_i (flags),
        .mask_i  (mask),
        .rdata_o (reg_rdata),
        .rvalid_o(reg_rvalid)
    );

    rp_irq_level #(.NSRC(NSRC)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags_i(flags),
        .mask_i (mask),
        .irq_o  (irq_o)
    );

    assign msi_fwd_o = msi_fwd_i;

    assert_irq_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|(flags & mask)) |=> irq_o);
    assert_irq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(flags & mask)) |=> !irq_o);
    assert_msi_no_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_fwd_i && !(|(flags & mask))) |=> !irq_o);
    assert_unmapped_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !flag_wr && !mask_wr) |=> $stable(mask));

endmodule

// File: tb/rp_irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module rp_irq_aggregator_tb_top;

    localparam logic [15:0] FLAG_A = 16'h3060;
    localparam logic [15:0] MASK_A = 16'h3070;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic [3:0]  intx_evt = '0;
    logic        cpl_evt = 1'b0;
    logic        msi_fwd_i = 1'b0;
    logic        msi_fwd_o, irq_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rp_irq_aggregator dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .intx_evt(intx_evt), .cpl_evt(cpl_evt),
        .msi_fwd_i(msi_fwd_i), .msi_fwd_o(msi_fwd_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check("R9 rvalid", {31'b0, reg_rvalid}, 32'd1);
        d = reg_rdata;
    endtask

    task automatic pulse(input logic [4:0] ev);
        intx_evt = ev[3:0]; cpl_evt = ev[4];
        @(negedge clk);
        intx_evt = '0; cpl_evt = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 irq", {31'b0, irq_o}, 32'd0);
        check("R1 rvalid", {31'b0, reg_rvalid}, 32'd0);
        rd(FLAG_A, v); check("R1 flags", v, 32'd0);
        rd(MASK_A, v); check("R1 mask", v, 32'd0);
        @(negedge clk);
        check("R9 rvalid drops", {31'b0, reg_rvalid}, 32'd0);

        // R2 R5 R6: every event pattern against every mask
        for (int ev = 0; ev < 32; ev++) begin
            for (int en = 0; en < 32; en++) begin
                wr(FLAG_A, 32'h1F);
                wr(MASK_A, 32'(en));
                pulse(5'(ev));
                @(negedge clk);
                check("R6 irq level", {31'b0, irq_o}, {31'b0, |(ev[4:0] & en[4:0])});
                rd(FLAG_A, v); check("R2 flags", v, 32'(ev));
                rd(MASK_A, v); check("R5 mask", v, 32'(en));
            end
        end

        // R3: every pending pattern against every clear mask
        wr(MASK_A, 32'h1F);
        for (int ev = 0; ev < 32; ev++) begin
            for (int m = 0; m < 32; m++) begin
                wr(FLAG_A, 32'h1F);
                pulse(5'(ev));
                wr(FLAG_A, 32'(m));
                rd(FLAG_A, v);
                check("R3 w1c", v, 32'(ev & ~m & 5'h1F));
                check("R6 irq after clear", {31'b0, irq_o}, {31'b0, |(ev[4:0] & ~m[4:0])});
            end
        end

        // R4 event and clear collide on the same flag
        for (int b = 0; b < 5; b++) begin
            wr(FLAG_A, 32'h1F);
            pulse(5'(1 << b));
            reg_addr = FLAG_A; reg_wdata = 32'(1 << b); reg_wr = 1'b1;
            intx_evt = 4'(1 << b); cpl_evt = (b == 4);
            @(negedge clk);
            reg_wr = 1'b0; intx_evt = '0; cpl_evt = 1'b0;
            rd(FLAG_A, v); check("R4 event wins", v, 32'(1 << b));
        end

        // R7 reserved bits
        wr(MASK_A, 32'hFFFF_FFE0);
        rd(MASK_A, v); check("R7 mask reserved", v, 32'd0);
        wr(MASK_A, 32'hFFFF_FFFF);
        rd(MASK_A, v); check("R7 mask reserved ones", v, 32'h1F);
        wr(FLAG_A, 32'h1F); pulse(5'h1F);
        wr(FLAG_A, 32'hFFFF_FFE0);
        rd(FLAG_A, v); check("R7 flag reserved", v, 32'h1F);

        // R8 unmapped offsets
        rd(16'h3064, v); check("R8 unmapped read", v, 32'd0);
        rd(16'h0000, v); check("R8 unmapped read 0", v, 32'd0);
        wr(16'h3064, 32'hFFFF_FFFF);
        wr(16'h3074, 32'h0);
        rd(FLAG_A, v); check("R8 flags untouched", v, 32'h1F);
        rd(MASK_A, v); check("R8 mask untouched", v, 32'h1F);

        // R9 back-to-back reads
        reg_addr = MASK_A; reg_rd = 1'b1;
        @(negedge clk);
        check("R9 stream 1", {31'b0, reg_rvalid}, 32'd1);
        reg_addr = FLAG_A;
        @(negedge clk);
        check("R9 stream 2", {31'b0, reg_rvalid}, 32'd1);
        check("R9 stream data", reg_rdata, 32'h1F);
        reg_rd = 1'b0;
        @(negedge clk);
        check("R9 retire", {31'b0, reg_rvalid}, 32'd0);

        // R10 message interrupts
        wr(FLAG_A, 32'h1F);
        msi_fwd_i = 1'b1;
        @(negedge clk);
        check("R10 forward", {31'b0, msi_fwd_o}, 32'd1);
        @(negedge clk);
        check("R10 no irq", {31'b0, irq_o}, 32'd0);
        msi_fwd_i = 1'b0;
        #1;
        check("R10 forward low", {31'b0, msi_fwd_o}, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule